// File: doc/BRIEF.md
# Conversion Start and Auto-Trigger Controller

This block decides when a converter begins a conversion. Software can request one directly through a start strobe. Alternatively, with automatic triggering switched on, a rising edge on one of several trigger inputs starts a conversion. A select code picks which input is used. Select code zero feeds the controller's own completion flag back as the trigger, so conversions run back to back.

Trigger inputs are asynchronous and pass through a synchronizer before an edge detector. The conversion engine is modelled as a counter of prescaled clock ticks. The prescaler is a free-running divider. A trigger-started conversion clears the prescaler, so the conversion length is exact. A software start leaves the prescaler running, so its length varies within one prescaler period.

The channel applied to a conversion is captured when that conversion starts. A new channel selection therefore applies from the next conversion onward. A completion flag records every finished conversion, whether or not the interrupt request is enabled.

Top module: `conv_trig_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_start`, `presc_rst`, `irq_flag`, `irq_req` are 0 and `conv_ch` is 0.
- R2: With `cfg_en` high and `busy` low, a `start_wr` strobe raises `conv_start` in that cycle and `busy` at the next clock edge, leaves `presc_rst` low, and `busy` then stays high for between (CONV_TICKS-1)*PRESC_DIV+1 and CONV_TICKS*PRESC_DIV cycles (17 to 20 by default).
- R3: While `cfg_en` is low, neither `start_wr` nor trigger edges start a conversion. Dropping `cfg_en` during a conversion clears `busy` at the next edge without setting `irq_flag`.
- R4: With `auto_en` high, `trig_sel`=k (1..NUM_EXT) selects `trig_in[k-1]`. Suppose that input rises just after a clock edge. Then `conv_start` and `presc_rst` are high in the cycle after the second following edge, `busy` rises at the third, and `busy` stays high for exactly CONV_TICKS*PRESC_DIV cycles. Edges on inputs that are not selected start nothing.
- R5: A trigger edge that arrives while `busy` is high is ignored, and the running conversion's length is unchanged.
- R6: A selected trigger still high when a conversion completes does not start another conversion.
- R7: `conv_ch` takes the value of `ch_sel` at the edge where `busy` rises and holds it for the whole conversion. A change of `ch_sel` during a conversion appears only at the next start.
- R8: `irq_flag` is set at the edge where a conversion completes, whatever `irq_en` is. `irq_req` equals `irq_flag` AND `irq_en`. `irq_clr` clears the flag, except that a completion in the same cycle wins.
- R9: With `trig_sel`=0 and `auto_en` high, a completion that raises `irq_flag` starts the next conversion (`conv_start`, `presc_rst`) in the following cycle. While the flag stays set, no further conversion starts.
- R10: A `start_wr` strobe while `busy` is high has no effect: no second conversion starts and the running one keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Converter enable |
| auto_en | input | 1 | Automatic trigger enable |
| trig_sel | input | SEL_W | Trigger source code, 0 = own completion flag |
| ch_sel | input | CH_W | Requested channel |
| start_wr | input | 1 | Software start strobe |
| irq_clr | input | 1 | Clear the completion flag |
| irq_en | input | 1 | Interrupt request enable |
| trig_in | input | NUM_EXT | Asynchronous trigger inputs |
| busy | output | 1 | Conversion in progress (start bit read-back) |
| conv_start | output | 1 | Start accepted this cycle |
| presc_rst | output | 1 | Prescaler restart for a trigger start |
| conv_ch | output | CH_W | Channel of current or last conversion |
| conv_done | output | 1 | Conversion completes this cycle |
| irq_flag | output | 1 | Completion flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A start accepted before each rise of `busy`, no start while busy, and a prescaler restart only together with a start are checked continuously. So are the channel holding steady within a conversion, the flag set at every enabled completion and the flag holding until cleared, and an idle converter while disabled. The scenarios alone show the exact trigger latency through the synchronizer, the exact and ranged conversion lengths, and that non-selected inputs, retriggers and still-high levels start nothing. They also show the free-running chain stopping on an uncleared flag and the set-over-clear priority.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;
    // select code that routes the completion flag back as trigger
    localparam int unsigned FREE_RUN_CODE = 0;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;
endpackage

// File: rtl/ctc_sync.sv
module ctc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], async_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign sync_out[i] = sh_q[STAGES-1];
    end
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ctc_engine.sv
module ctc_engine
    import conv_trig_pkg::*;
#(
    parameter int TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic abort,
    input  logic tick,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);

    eng_state_e    st_d, st_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        done  = 1'b0;
        if (abort) begin
            st_d  = ENG_IDLE;
            cnt_d = '0;
        end else if (go && st_q == ENG_IDLE) begin
            st_d  = ENG_RUN;
            cnt_d = CW'(TICKS);
        end else if (st_q == ENG_RUN && tick) begin
            if (cnt_q == CW'(1)) begin
                done  = 1'b1;
                st_d  = ENG_IDLE;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ENG_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign busy = (st_q == ENG_RUN);
endmodule

// File: rtl/conv_trig_ctrl.sv
module conv_trig_ctrl
    import conv_trig_pkg::*;
#(
    parameter int NUM_EXT     = 3,
    parameter int SEL_W       = $clog2(NUM_EXT + 1),
    parameter int CH_W        = 3,
    parameter int PRESC_DIV   = 4,
    parameter int CONV_TICKS  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               auto_en,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [CH_W-1:0]    ch_sel,
    input  logic               start_wr,
    input  logic               irq_clr,
    input  logic               irq_en,
    input  logic [NUM_EXT-1:0] trig_in,
    output logic               busy,
    output logic               conv_start,
    output logic               presc_rst,
    output logic [CH_W-1:0]    conv_ch,
    output logic               conv_done,
    output logic               irq_flag,
    output logic               irq_req
);
    typedef struct packed {
        logic            irq;
        logic            prev;
        logic [CH_W-1:0] ch;
    } ctrl_t;

    ctrl_t              st_d, st_q;
    logic [NUM_EXT-1:0] trig_s;
    logic               sel_lvl, edge_seen, auto_go, sw_go, go;
    logic               eng_busy, eng_done, tick;

    ctc_sync #(.N(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .sync_out (trig_s)
    );

    ctc_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (auto_go | ~cfg_en),
        .tick  (tick)
    );

    ctc_engine #(.TICKS(CONV_TICKS)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .abort (~cfg_en),
        .tick  (tick),
        .busy  (eng_busy),
        .done  (eng_done)
    );

    always_comb begin
        // trigger source mux
        sel_lvl = 1'b0;
        if (trig_sel == SEL_W'(FREE_RUN_CODE)) begin
            sel_lvl = st_q.irq;
        end else begin
            for (int i = 0; i < NUM_EXT; i++) begin
                if (trig_sel == SEL_W'(i + 1)) sel_lvl = trig_s[i];
            end
        end

        edge_seen = sel_lvl & ~st_q.prev;
        auto_go   = cfg_en & auto_en & edge_seen & ~eng_busy;
        sw_go     = cfg_en & start_wr & ~eng_busy;
        go        = auto_go | sw_go;

        st_d      = st_q;
        st_d.prev = sel_lvl;
        if (go) st_d.ch = ch_sel;
        if (eng_done)     st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = eng_busy;
    assign conv_start = go;
    assign presc_rst  = auto_go;
    assign conv_ch    = st_q.ch;
    assign conv_done  = eng_done;
    assign irq_flag   = st_q.irq;
    assign irq_req    = st_q.irq & irq_en;
endmodule

// File: rtl/conv_trig_ctrl_chk.sv
module conv_trig_ctrl_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            irq_clr,
    input logic            busy,
    input logic            conv_start,
    input logic            presc_rst,
    input logic [CH_W-1:0] conv_ch,
    input logic            irq_flag
);
    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_start));

    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !busy);

    // R4
    presc_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |-> conv_start);

    // R5
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !conv_start);

    // R7
    ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(conv_ch));

    // R8
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(cfg_en)) |-> irq_flag);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_flag) && !$past(irq_clr)) |-> irq_flag);
endmodule

bind conv_trig_ctrl conv_trig_ctrl_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .irq_clr    (irq_clr),
    .busy       (busy),
    .conv_start (conv_start),
    .presc_rst  (presc_rst),
    .conv_ch    (conv_ch),
    .irq_flag   (irq_flag)
);

// File: tb/conv_trig_ctrl_bench.sv
module conv_trig_ctrl_bench;
    localparam int NE = 3, SW = 2, CW = 3, DIV = 4, TK = 5;
    localparam int FULL = TK * DIV;
    localparam int MINL = (TK - 1) * DIV + 1;

    logic clk = 0, rst_n = 0;
    logic cfg_en = 0, auto_en = 0, start_wr = 0, irq_clr = 0, irq_en = 0;
    logic [SW-1:0] trig_sel = '0;
    logic [CW-1:0] ch_sel = '0;
    logic [NE-1:0] trig_in = '0;
    logic busy, conv_start, presc_rst, conv_done, irq_flag, irq_req;
    logic [CW-1:0] conv_ch;

    int n_chk = 0, n_fail = 0, cur = 0, len = 0, cnt = 0;
    logic [CW-1:0] new_ch = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    conv_trig_ctrl #(.NUM_EXT(NE), .SEL_W(SW), .CH_W(CW), .PRESC_DIV(DIV),
                     .CONV_TICKS(TK), .SYNC_STAGES(2)) u_conv_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .auto_en(auto_en),
        .trig_sel(trig_sel), .ch_sel(ch_sel), .start_wr(start_wr),
        .irq_clr(irq_clr), .irq_en(irq_en), .trig_in(trig_in),
        .busy(busy), .conv_start(conv_start), .presc_rst(presc_rst),
        .conv_ch(conv_ch), .conv_done(conv_done), .irq_flag(irq_flag),
        .irq_req(irq_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // counts cycles with busy high among n samples
    task automatic busy_count(input int n);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (busy) cnt++;
        end
    endtask

    task automatic clear_flag();
        irq_clr = 1; step(1); irq_clr = 0;
    endtask

    // fire selected input idx, check latency (R4)
    task automatic fire(input int idx);
        trig_in[idx] = 1'b1;
        step(1);
        chk(busy == 0, "R4", busy, 0);
        step(1);
        chk(conv_start && presc_rst, "R4", {conv_start, presc_rst}, 3);
        step(1);
        chk(busy == 1, "R4", busy, 1);
    endtask

    // measure busy length; act: 1 retrigger, 2 channel change,
    // 3 start strobe, 4 disable, 5 clear flag in completion cycle
    task automatic watch(input int at, input int act);
        len = 0;
        while (busy && len < 100) begin
            if (len == at) begin
                case (act)
                    1: trig_in[cur] = 1'b0;
                    2: ch_sel = new_ch;
                    3: start_wr = 1'b1;
                    4: cfg_en = 1'b0;
                    5: irq_clr = 1'b1;
                    default: ;
                endcase
            end
            if (len == at + 1 && act == 3) start_wr = 1'b0;
            if (len == at + 3 && act == 1) trig_in[cur] = 1'b1;
            len++;
            @(negedge clk);
        end
        irq_clr = 1'b0;
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk(!busy && !conv_start && !presc_rst && !irq_flag && !irq_req && conv_ch == 0,
            "R1", {busy, conv_start, presc_rst, irq_flag, irq_req}, 0);

        // R3 disabled: nothing starts
        auto_en = 1; trig_sel = 1;
        start_wr = 1; step(1); start_wr = 0;
        trig_in = '1;
        busy_count(10);
        chk(cnt == 0 && !irq_flag, "R3", cnt, 0);
        auto_en = 0; trig_in = '0; step(4);
        cfg_en = 1; step(2);

        // R4 sweep over sources and channels
        for (int s = 1; s <= NE; s++) begin
            for (int c = 0; c < (1 << CW); c++) begin
                auto_en = 0; trig_sel = SW'(s); ch_sel = CW'(c);
                irq_en = c[0]; trig_in = '0;
                step(4);
                auto_en = 1;
                trig_in[s % NE] = 1'b1;
                busy_count(6);
                chk(cnt == 0, "R4 unselected", cnt, 0);
                trig_in[s % NE] = 1'b0;
                step(4);
                fire(s - 1);
                chk(conv_ch == CW'(c), "R7", conv_ch, c);
                watch(-1, 0);
                chk(len == FULL, "R4 length", len, FULL);
                chk(irq_flag == 1, "R8", irq_flag, 1);
                chk(irq_req == c[0], "R8 req", irq_req, c[0]);
                clear_flag();
                step(1);
                chk(irq_flag == 0, "R8 clear", irq_flag, 0);
                trig_in = '0;
                step(3);
            end
        end

        // R5 retrigger ignored, R6 no restart on held level
        trig_sel = 2; cur = 1; step(4);
        fire(cur);
        watch(8, 1);
        chk(len == FULL, "R5", len, FULL);
        busy_count(30);
        chk(cnt == 0, "R6", cnt, 0);
        clear_flag(); trig_in = '0; step(4);

        // R7 channel change mid-conversion
        ch_sel = 2; new_ch = 5;
        fire(cur);
        watch(5, 2);
        chk(conv_ch == 2, "R7 hold", conv_ch, 2);
        trig_in = '0; clear_flag(); step(4);
        fire(cur);
        chk(conv_ch == 5, "R7 next", conv_ch, 5);
        watch(-1, 0);
        trig_in = '0; clear_flag(); step(4);

        // R8 set wins over clear in completion cycle
        fire(cur);
        watch(FULL - 1, 5);
        chk(!busy && irq_flag, "R8 priority", irq_flag, 1);
        trig_in = '0; clear_flag(); step(4);

        // R3 abort mid-conversion
        fire(cur);
        watch(5, 4);
        chk(len == 6 && !irq_flag, "R3 abort", len, 6);
        cfg_en = 1; trig_in = '0; step(4);

        // R2 software start at every prescaler phase, R10 strobe while busy
        auto_en = 0;
        for (int off = 0; off < DIV; off++) begin
            step(off);
            start_wr = 1;
            #1;
            chk(conv_start && !presc_rst, "R2", {conv_start, presc_rst}, 2);
            step(1);
            start_wr = 0;
            chk(busy == 1, "R2", busy, 1);
            watch(6, 3);
            chk(len >= MINL && len <= FULL, "R2 length", len, FULL);
            busy_count(10);
            chk(cnt == 0, "R10", cnt, 0);
            clear_flag(); step(2);
        end

        // R9 free-running chain
        trig_sel = 0; step(3); auto_en = 1; step(2);
        start_wr = 1; step(1); start_wr = 0;
        watch(-1, 0);
        chk(irq_flag && conv_start && presc_rst, "R9 chain",
            {irq_flag, conv_start, presc_rst}, 7);
        step(1);
        chk(busy == 1, "R9", busy, 1);
        watch(-1, 0);
        chk(len == FULL, "R9 length", len, FULL);
        busy_count(30);
        chk(cnt == 0, "R9 flag set", cnt, 0);
        clear_flag();
        busy_count(10);
        chk(cnt == 0, "R9 cleared idle", cnt, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule